// File: doc/BRIEF.md
# Grouped Event Interrupt Status Register

This block collects ten single-cycle event pulses raised by a DMA bridge and holds them in one 32-bit control/status word. Two events come from a USB DMA path: transfer complete and address fault. The other eight come from two audio channels. Each channel has a playback and a capture direction, and each direction reports a half-buffer event and a full-buffer event. Every event has a sticky status flag and an enable flag. Three level-sensitive interrupt lines are formed from them, grouped by the kind of event rather than by its source.

Software reads the word to see which events are enabled and which are pending. A write to the word sets all enable flags at once. In the same write, a 0 acknowledges a status flag and a 1 leaves it unchanged. Status bits latch even while their event is masked. When a pulse arrives in the same cycle as an acknowledge of that bit, the pulse wins and the event is kept.

Top module: `grp_evt_csr`

## Requirements
- R1: While reset is asserted and right after it, the read word is all zero and all three interrupt lines are low.
- R2: A pulse on event n sets its status bit. Event 0 (USB transfer done) uses bit 0 and event 1 (USB address fault) uses bit 1. Events 2..9 use bit 14+n. Events 2..9 are, in order: channel 0 play full, channel 0 play half, channel 0 capture full, channel 0 capture half, then the same four for channel 1.
- R3: The enable bit of event n sits 8 positions above its status bit. A write loads each enable bit with the written value, and the enable bits hold their value when there is no write.
- R4: A status bit latches its event whether or not the event is enabled, and it is visible on the read word in the cycle after the pulse.
- R5: A write with 0 in a status bit position clears that status bit. A write with 1 in that position leaves the bit unchanged.
- R6: An event pulse in the same cycle as a write of 0 to its status bit leaves the bit set.
- R7: Line 0 is high exactly when event 1 is both pending and enabled.
- R8: Line 1 is high exactly when any of events 0, 2, 4, 6 or 8 is both pending and enabled.
- R9: Line 2 is high exactly when any of events 3, 5, 7 or 9 is both pending and enabled.
- R10: Bits 15..10 and 7..2 always read 0, and writes to them have no effect.
- R11: An interrupt line stays high until every enabled, pending contributor is cleared or masked. All outputs are combinational from the held state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control/status word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Current control/status word |
| evt_i | input | 10 | Event pulses, bit n is event n |
| irq_o | output | 3 | Grouped interrupt lines |

## Verification
The first pattern pulses single events with every enable off. It separates the status-bit placement from the interrupt grouping and shows that masking does not stop latching. The same single pulses are then repeated with every enable on, which pins each event to exactly one line. Writes of all ones and of all zeros tell acknowledge apart from no-change and show the reserved bits are ignored. A pulse coincident with its own acknowledge checks the set-over-clear priority. A long pseudo-random mix of overlapping pulses, partial enable writes and partial acknowledges checks that lines stay high until the last contributor goes.

// File: rtl/grp_evt_pkg.sv
package grp_evt_pkg;
  localparam int NUM_EVT = 10;
  localparam int NUM_IRQ = 3;
  localparam int REG_W   = 32;
  localparam int USB_EVT = 2;
  localparam int USB_ST_BASE = 0;
  localparam int AUD_ST_BASE = 16;
  localparam int EN_OFFSET   = 8;

  function automatic int status_bit(input int n);
    return (n < USB_EVT) ? USB_ST_BASE + n : AUD_ST_BASE + (n - USB_EVT);
  endfunction

  function automatic int enable_bit(input int n);
    return status_bit(n) + EN_OFFSET;
  endfunction

  // line 0: USB fault; line 1: transfer/full-buffer; line 2: half-buffer
  function automatic int irq_line(input int n);
    if (n == 1) return 0;
    if (n == 0) return 1;
    return (((n - USB_EVT) % 2) == 0) ? 1 : 2;
  endfunction

  function automatic logic [NUM_EVT-1:0] group_mask(input int g);
    logic [NUM_EVT-1:0] m;
    m = '0;
    for (int n = 0; n < NUM_EVT; n++)
      if (irq_line(n) == g) m[n] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] live_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int n = 0; n < NUM_EVT; n++) begin
      m[status_bit(n)] = 1'b1;
      m[enable_bit(n)] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/grp_evt_cell.sv
module grp_evt_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic wr_i,
  input  logic st_wbit_i,
  input  logic en_wbit_i,
  output logic status_o,
  output logic enable_o,
  output logic pend_o
);
  logic st_q, en_q;
  logic clr_req;

  assign clr_req = wr_i & ~st_wbit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= 1'b0;
      en_q <= 1'b0;
    end else begin
      if (wr_i) en_q <= en_wbit_i;
      if (evt_i) st_q <= 1'b1;
      else if (clr_req) st_q <= 1'b0;
    end
  end

  assign status_o = st_q;
  assign enable_o = en_q;
  assign pend_o   = st_q & en_q;

  p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> status_o);
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && clr_req) |=> status_o);
  p_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !evt_i) |=> !status_o);
  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i && !clr_req) |=> $stable(status_o));
  p_en_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (enable_o == $past(en_wbit_i)));
  p_en_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(enable_o));
endmodule

// File: rtl/grp_evt_fanin.sv
module grp_evt_fanin
  import grp_evt_pkg::*;
#(
  parameter int N_EVT = NUM_EVT,
  parameter int N_IRQ = NUM_IRQ
) (
  input  logic [N_EVT-1:0] pend_i,
  output logic [N_IRQ-1:0] irq_o
);
  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    localparam logic [N_EVT-1:0] LINE_MASK = N_EVT'(group_mask(g));
    assign irq_o[g] = |(pend_i & LINE_MASK);
  end
endmodule

// File: rtl/grp_evt_csr.sv
module grp_evt_csr
  import grp_evt_pkg::*;
#(
  parameter int N_EVT = NUM_EVT,
  parameter int N_IRQ = NUM_IRQ,
  parameter int W     = REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rdata_o,
  input  logic [N_EVT-1:0] evt_i,
  output logic [N_IRQ-1:0] irq_o
);
  localparam logic [W-1:0] LIVE = W'(live_mask());

  logic [N_EVT-1:0] status_w, enable_w, pend_w;

  for (genvar n = 0; n < N_EVT; n++) begin : g_cell
    localparam int SB = status_bit(n);
    localparam int EB = enable_bit(n);
    grp_evt_cell i_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i[n]),
      .wr_i     (wr_en_i),
      .st_wbit_i(wdata_i[SB]),
      .en_wbit_i(wdata_i[EB]),
      .status_o (status_w[n]),
      .enable_o (enable_w[n]),
      .pend_o   (pend_w[n])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < N_EVT; n++) begin
      rdata_o[status_bit(n)] = status_w[n];
      rdata_o[enable_bit(n)] = enable_w[n];
    end
  end

  grp_evt_fanin #(.N_EVT(N_EVT), .N_IRQ(N_IRQ)) i_fanin (
    .pend_i(pend_w),
    .irq_o (irq_o)
  );

  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o & ~LIVE) == '0);
  p_line0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[0] == (rdata_o[1] & rdata_o[9]));
  p_line1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[1] == ((rdata_o[0] & rdata_o[8]) |
                 (|(rdata_o[23:16] & rdata_o[31:24] & 8'h55))));
  p_line2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[2] == (|(rdata_o[23:16] & rdata_o[31:24] & 8'hAA)));
endmodule

// File: tb/test_grp_evt_csr.sv
module test_grp_evt_csr;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [NE-1:0] evt;
  logic [2:0]  irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string tag = "R1 reset";

  bit m_st[NE];
  bit m_en[NE];

  always #(CLK_PERIOD/2) clk = ~clk;

  grp_evt_csr i_grp_evt_csr (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  function automatic int spos(int n);
    if (n < 2) return n;
    return n + 14;
  endfunction

  function automatic int line_of(int n);
    if (n == 1) return 0;
    if (n == 0 || (n % 2) == 0) return 1;
    return 2;
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    for (int n = 0; n < NE; n++) begin
      w[spos(n)]     = m_st[n];
      w[spos(n) + 8] = m_en[n];
    end
    return w;
  endfunction

  function automatic logic [2:0] exp_irq();
    logic [2:0] q = '0;
    for (int n = 0; n < NE; n++)
      if (m_st[n] && m_en[n]) q[line_of(n)] = 1'b1;
    return q;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NE; n++) begin m_st[n] = 0; m_en[n] = 0; end
    end else begin
      for (int n = 0; n < NE; n++) begin
        if (wr_en) m_en[n] = wdata[spos(n) + 8];
        if (evt[n]) m_st[n] = 1;
        else if (wr_en && !wdata[spos(n)]) m_st[n] = 0;
      end
    end
  end

  task automatic compare();
    logic [31:0] ew = exp_word();
    logic [2:0]  ei = exp_irq();
    checks++;
    if (rdata !== ew) begin
      fails++;
      $display("FAIL %s word: got %h expected %h", tag, rdata, ew);
    end
    checks++;
    if (irq !== ei) begin
      fails++;
      $display("FAIL %s irq: got %b expected %b", tag, irq, ei);
    end
  endtask

  task automatic step(input logic [NE-1:0] e, input logic w,
                      input logic [31:0] d, input string t);
    @(negedge clk);
    compare();
    evt = e; wr_en = w; wdata = d; tag = t;
  endtask

  localparam logic [31:0] ALL_EN = 32'hFF00_0300;

  initial begin
    rst_n = 0; wr_en = 0; wdata = '0; evt = '0;
    repeat (3) step('0, 0, '0, "R1 reset");
    @(negedge clk); rst_n = 1;
    step('0, 0, '0, "R1 after reset");
    // enables only, through a write that also has reserved bits set
    step('0, 1, 32'hFFFF_FFFF, "R10 reserved write R3 enable set");
    step('0, 0, '0, "R3 hold");
    step('0, 1, 32'h0000_0000, "R3 enable clear");
    // masked single pulses
    for (int n = 0; n < NE; n++) begin
      step(NE'(1) << n, 0, '0, "R4 masked latch R2 position");
      step('0, 0, '0, "R4 masked latch R2 position");
    end
    step('0, 1, 32'hFFFF_FFFF, "R5 write one keeps status R7 R8 R9");
    step('0, 0, '0, "R11 lines held");
    step('0, 1, 32'h0000_0000, "R5 ack all");
    // enabled single pulses, one at a time, acknowledged afterwards
    step('0, 1, ALL_EN, "R3 enable all");
    for (int n = 0; n < NE; n++) begin
      step(NE'(1) << n, 0, '0, "R7 R8 R9 single line");
      step('0, 0, '0, "R7 R8 R9 single line");
      step('0, 1, ALL_EN, "R5 ack keeps enables");
    end
    // set wins over clear
    step(10'h3FF, 1, ALL_EN, "R6 set beats ack");
    step('0, 0, '0, "R6 set beats ack");
    // partial acknowledge: drop one contributor of line 1 at a time
    step('0, 1, ALL_EN | 32'h00FF_0003 & ~32'h0000_0001, "R11 partial ack");
    step('0, 1, ALL_EN | 32'h00AA_0002, "R11 partial ack");
    step('0, 1, 32'h0000_0000 | 32'h00FF_0003, "R11 mask all");
    step('0, 1, ALL_EN, "R5 ack all");
    // pseudo-random mix
    for (int i = 0; i < 400; i++) begin
      logic [NE-1:0] e = NE'($urandom & $urandom & $urandom);
      logic w = (($urandom % 4) == 0);
      step(e, w, $urandom, "R11 random mix R2 R3 R4 R5 R6");
    end
    step('0, 0, '0, "R11 random mix");
    step('0, 0, '0, "R11 random mix");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule